// File: doc/BRIEF.md
# Chained Difference Pattern Rebuilder

This block sits between a field decoder and a scan loader in a processor-free test path. It rebuilds deterministic test vectors that have been stored as small edits to an existing vector. A record starts with a gap to the index of a base random vector. The block keeps a running index, adds that gap to it, and shows the result on `idx_out`. The random source answers on `base_vec`, and the block copies that vector into a working register.

Next comes the number of deterministic vectors that hang off this base. For each of them the record gives a flip count and then that many position gaps. Each listed bit of the working register is inverted. When the last flip of a vector is done, the vector is presented for one cycle with `pat_valid`. The next vector in the record starts from that rebuilt vector, not from the base. Bits that are never listed keep the value they had in the base vector.

Fields are pulled only when the state machine needs one (`fld_ready`), so decoding runs in step with test application. A position that falls outside the vector raises `err` for one cycle and drops the rest of the record.

States:
- `ST_IDLE`: waits for an index gap.
- `ST_LOAD`: copies the base vector.
- `ST_COUNT`: takes the pattern count.
- `ST_FLIPS`: takes a flip count.
- `ST_GAP`: takes position gaps and inverts bits.
- `ST_EMIT`: presents a rebuilt vector.
- `ST_ABORT`: flags a bad position.

Transitions:
- `ST_IDLE`→`ST_LOAD` on a taken field.
- `ST_LOAD`→`ST_COUNT` always.
- `ST_COUNT`→`ST_IDLE` when the count is zero, otherwise →`ST_FLIPS`.
- `ST_FLIPS`→`ST_EMIT` when the flip count is zero, otherwise →`ST_GAP`.
- `ST_GAP`→`ST_ABORT` on an out-of-range position, →`ST_EMIT` after the last gap, otherwise it stays in `ST_GAP`.
- `ST_EMIT`→`ST_IDLE` after the last vector of the record, otherwise →`ST_FLIPS`.
- `ST_ABORT`→`ST_IDLE` always.

Top module: `diffpat_rebuild`

## Requirements
- R1: After reset, `fld_ready`=1, `pat_valid`=0, `err`=0 and `idx_out`=0.
- R2: The first field of a record is a gap. `idx_out` becomes the previous index plus that gap (modulo 2^IW) on the edge that takes the field, and it changes at no other time.
- R3: The first vector of a record equals `base_vec`, sampled one cycle after the gap was taken, with each listed position inverted. Unlisted bits keep their base value.
- R4: Every later vector of a record starts from the vector emitted just before it. `pat_out` holds its value through the cycle after a strobe.
- R5: Positions are gap coded. The first position equals the first gap, and each later position is the previous position plus its gap. A position listed twice is inverted twice.
- R6: A flip count of zero emits the current working vector unchanged.
- R7: A pattern count of zero emits nothing, and the next field starts a new record.
- R8: A position of W or more raises `err` for exactly one cycle, emits no vector, and abandons the record. The next field taken is the gap of a new record.
- R9: `pat_valid` lasts one cycle per vector. `fld_ready` is low while a base is loaded, while a vector is presented, and while an error is flagged.
- R10: `pat_valid` is high in the cycle right after the edge that took the last position gap, or the zero flip count, of that vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_valid | input | 1 | Decoded field present |
| fld_data | input | FW | Decoded field value |
| fld_ready | output | 1 | Block takes a field this cycle |
| base_vec | input | W | Random vector for the index on `idx_out` |
| idx_out | output | IW | Running base vector index |
| pat_valid | output | 1 | Rebuilt vector strobe |
| pat_out | output | W | Rebuilt vector |
| err | output | 1 | Out-of-range position flag |

## Verification
An index gap taken at edge n shows on `idx_out` just after n. At that same point `fld_ready` is low, because the base is being loaded. The base is copied at edge n+1. A vector whose last gap is taken at edge m is strobed in the cycle between m and m+1, and an out-of-range position taken at m raises `err` in that same window. The bench feeds fields through a task that returns at the falling edge after the taking edge, so it samples these results at exactly that point. A behavioural model, built from a queue of expected vectors and errors, is compared with the outputs on every falling edge, and any strobe that is not expected counts as a failure.

// File: rtl/diffpat_pkg.sv
package diffpat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COUNT,
        ST_FLIPS,
        ST_GAP,
        ST_EMIT,
        ST_ABORT
    } rb_state_t;

endpackage

// File: rtl/diffpat_poscalc.sv
module diffpat_poscalc #(
    parameter int W  = 32,
    parameter int FW = 16
) (
    input  logic [FW-1:0]          prev,
    input  logic [FW-1:0]          gap,
    output logic [$clog2(W)-1:0]   pos,
    output logic                   over
);
    localparam int PW = $clog2(W);

    logic [FW:0] sum;

    always_comb begin
        sum  = {1'b0, prev} + {1'b0, gap};
        over = (sum >= (FW+1)'(W));
        pos  = sum[PW-1:0];
    end
endmodule

// File: rtl/diffpat_flipper.sv
module diffpat_flipper #(
    parameter int W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [W-1:0]          load_vec,
    input  logic                  flip_en,
    input  logic [$clog2(W)-1:0]  flip_pos,
    output logic [W-1:0]          vec
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    vec[b] <= 1'b0;
                else if (load)
                    vec[b] <= load_vec[b];
                else if (flip_en && (flip_pos == b))
                    vec[b] <= ~vec[b];
            end
        end
    endgenerate
endmodule

// File: rtl/diffpat_rebuild.sv
module diffpat_rebuild
    import diffpat_pkg::*;
#(
    parameter int W  = 32,
    parameter int FW = 16,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fld_valid,
    input  logic [FW-1:0] fld_data,
    output logic          fld_ready,
    input  logic [W-1:0]  base_vec,
    output logic [IW-1:0] idx_out,
    output logic          pat_valid,
    output logic [W-1:0]  pat_out,
    output logic          err
);
    localparam int PW = $clog2(W);

    rb_state_t     state, state_nx;
    logic          take;
    logic          load_en;
    logic          flip_en;
    logic [FW-1:0] rem_pats;
    logic [FW-1:0] left_flips;
    logic [FW-1:0] prev_pos;
    logic [PW-1:0] pos;
    logic          over;

    assign take = fld_valid && fld_ready;

    diffpat_poscalc #(.W(W), .FW(FW)) u_pos (
        .prev (prev_pos),
        .gap  (fld_data),
        .pos  (pos),
        .over (over)
    );

    diffpat_flipper #(.W(W)) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_vec (base_vec),
        .flip_en  (flip_en),
        .flip_pos (pos),
        .vec      (pat_out)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (take) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ST_COUNT;
            ST_COUNT: if (take) state_nx = (fld_data == '0) ? ST_IDLE : ST_FLIPS;
            ST_FLIPS: if (take) state_nx = (fld_data == '0) ? ST_EMIT : ST_GAP;
            ST_GAP: begin
                if (take) begin
                    if (over)
                        state_nx = ST_ABORT;
                    else if (left_flips == FW'(1))
                        state_nx = ST_EMIT;
                end
            end
            ST_EMIT:  state_nx = (rem_pats == FW'(1)) ? ST_IDLE : ST_FLIPS;
            ST_ABORT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        fld_ready = 1'b0;
        pat_valid = 1'b0;
        err       = 1'b0;
        load_en   = 1'b0;
        flip_en   = 1'b0;
        unique case (state)
            ST_IDLE, ST_COUNT, ST_FLIPS: fld_ready = 1'b1;
            ST_GAP: begin
                fld_ready = 1'b1;
                flip_en   = fld_valid && !over;
            end
            ST_LOAD:  load_en   = 1'b1;
            ST_EMIT:  pat_valid = 1'b1;
            ST_ABORT: err       = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_out    <= '0;
            rem_pats   <= '0;
            left_flips <= '0;
            prev_pos   <= '0;
        end else begin
            if (state == ST_IDLE && take)
                idx_out <= idx_out + IW'(fld_data);
            if (state == ST_COUNT && take)
                rem_pats <= fld_data;
            if (state == ST_EMIT)
                rem_pats <= rem_pats - FW'(1);
            if (state == ST_FLIPS && take) begin
                left_flips <= fld_data;
                prev_pos   <= '0;
            end
            if (flip_en) begin
                left_flips <= left_flips - FW'(1);
                prev_pos   <= FW'(pos);
            end
        end
    end
endmodule

// File: rtl/diffpat_rebuild_chk.sv
module diffpat_rebuild_chk #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fld_valid,
    input logic          fld_ready,
    input logic [IW-1:0] idx_out,
    input logic          pat_valid,
    input logic [W-1:0]  pat_out,
    input logic          err
);
    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |=> !pat_valid);

    assert_no_take_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |-> !fld_ready);

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !pat_valid));

    assert_idx_moves_on_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx_out) |-> $past(fld_valid && fld_ready));

    assert_vec_held_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |=> $stable(pat_out));
endmodule

bind diffpat_rebuild diffpat_rebuild_chk #(.W(W), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fld_valid (fld_valid),
    .fld_ready (fld_ready),
    .idx_out   (idx_out),
    .pat_valid (pat_valid),
    .pat_out   (pat_out),
    .err       (err)
);

// File: tb/diffpat_rebuild_test.sv
module diffpat_rebuild_test;
    localparam int W  = 32;
    localparam int FW = 16;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fld_valid = 1'b0;
    logic [FW-1:0] fld_data = '0;
    logic          fld_ready;
    logic [W-1:0]  base_vec;
    logic [IW-1:0] idx_out;
    logic          pat_valid;
    logic [W-1:0]  pat_out;
    logic          err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] exp_vec[$];
    bit           exp_err[$];
    string        exp_tag[$];

    int           ref_idx = 0;
    logic [W-1:0] ref_vec;

    always #2 clk = ~clk;

    function automatic logic [W-1:0] rnd(input logic [IW-1:0] i);
        logic [31:0] x;
        x = {16'h0, i} * 32'h9E3779B1;
        x = x ^ (x >> 13) ^ 32'h5BD1E995;
        return x[W-1:0];
    endfunction

    assign base_vec = rnd(idx_out);

    diffpat_rebuild #(.W(W), .FW(FW), .IW(IW)) uut (
        .clk(clk), .rst_n(rst_n), .fld_valid(fld_valid), .fld_data(fld_data),
        .fld_ready(fld_ready), .base_vec(base_vec), .idx_out(idx_out),
        .pat_valid(pat_valid), .pat_out(pat_out), .err(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (pat_valid || err) begin
                if (exp_vec.size() == 0) begin
                    check(0, "R7", "unexpected output", {31'b0, err}, '0);
                end else begin
                    logic [W-1:0] v;
                    bit e;
                    string t;
                    v = exp_vec.pop_front();
                    e = exp_err.pop_front();
                    t = exp_tag.pop_front();
                    check(err == e && pat_valid == !e, t, "strobe kind",
                          {30'b0, err, pat_valid}, {30'b0, e, !e});
                    if (!e) check(pat_out == v, t, "rebuilt vector", pat_out, v);
                end
            end
        end
    end

    // Present one field; return at the falling edge after it was taken
    task automatic send(input int v, input int idle);
        repeat (idle) @(negedge clk);
        fld_valid = 1'b1;
        fld_data  = FW'(v);
        while (!fld_ready) @(negedge clk);
        @(negedge clk);
        fld_valid = 1'b0;
    endtask

    task automatic begin_rec(input int gap, input int cnt);
        ref_idx = (ref_idx + gap) % (1 << IW);
        send(gap, 0);
        check(idx_out == IW'(ref_idx), "R2", "index", W'(idx_out), W'(ref_idx));
        check(fld_ready == 1'b0, "R9", "ready during load", W'(fld_ready), '0);
        ref_vec = rnd(IW'(ref_idx));
        send(cnt, 0);
    endtask

    task automatic pat(input int n, input int g[4], input string tag, output bit aborted);
        int prev;
        aborted = 0;
        prev = 0;
        send(n, 0);
        if (n == 0) begin
            exp_vec.push_back(ref_vec); exp_err.push_back(0); exp_tag.push_back(tag);
            check(pat_valid == 1'b1, "R10", "strobe timing", W'(pat_valid), 1);
            return;
        end
        for (int i = 0; i < n; i++) begin
            int p;
            p = prev + g[i];
            if (p >= W) begin
                exp_vec.push_back('0); exp_err.push_back(1); exp_tag.push_back("R8");
                send(g[i], (i == 1) ? 2 : 0);
                check(err == 1'b1, "R8", "error timing", W'(err), 1);
                aborted = 1;
                return;
            end
            ref_vec[p] = ~ref_vec[p];
            prev = p;
            if (i == n - 1) begin
                exp_vec.push_back(ref_vec); exp_err.push_back(0); exp_tag.push_back(tag);
            end
            send(g[i], (i == 1) ? 2 : 0);
        end
        check(pat_valid == 1'b1, "R10", "strobe timing", W'(pat_valid), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ab;
        repeat (3) @(negedge clk);
        check(fld_ready == 1'b1 && pat_valid == 1'b0 && err == 1'b0 && idx_out == '0,
              "R1", "reset state", {fld_ready, pat_valid, err, W'(idx_out)}[W-1:0],
              {1'b1, 2'b0, W'(0)}[W-1:0]);
        rst_n = 1'b1;
        @(negedge clk);
        check(fld_ready == 1'b1 && idx_out == '0, "R1", "after reset",
              W'(idx_out), '0);

        // first record: base plus four chained vectors
        begin_rec(36, 4);
        pat(3, '{1, 4, 10, 0}, "R3", ab);
        pat(3, '{0, 7, 24, 0}, "R4", ab);
        pat(1, '{20, 0, 0, 0}, "R4", ab);
        pat(2, '{2, 2, 0, 0}, "R5", ab);

        // zero flip count, and a repeated position
        begin_rec(5, 2);
        pat(0, '{0, 0, 0, 0}, "R6", ab);
        pat(2, '{31, 0, 0, 0}, "R5", ab);

        // empty record
        begin_rec(3, 0);
        repeat (2) @(negedge clk);
        check(exp_vec.size() == 0, "R7", "no pending output", W'(exp_vec.size()), '0);

        // out-of-range position aborts the record
        begin_rec(1, 2);
        pat(1, '{8, 0, 0, 0}, "R3", ab);
        pat(2, '{30, 5, 0, 0}, "R8", ab);
        check(ab == 1, "R8", "abort seen by model", W'(ab), 1);
        @(negedge clk);
        check(fld_ready == 1'b1 && err == 1'b0, "R8", "back to record start",
              {30'b0, fld_ready, err}, 2);

        // recovery record
        begin_rec(2, 1);
        pat(1, '{0, 0, 0, 0}, "R8", ab);

        // large index gap wraps
        begin_rec(65530, 1);
        pat(2, '{3, 9, 0, 0}, "R2", ab);

        repeat (3) @(negedge clk);
        check(exp_vec.size() == 0, "R9", "all outputs seen", W'(exp_vec.size()), '0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule